// File: doc/BRIEF.md
# UART modem flow-control unit

This block sits between a UART's serial shifters, its receive FIFO and the modem pins. It decides when the transmitter may launch a frame and when a detected start bit may begin a reception. It also drives the RTS pin and can force the TXD line low to send a break. The baud generator, the shift registers and the FIFO storage are outside the block. They appear only as a frame-done strobe, a start-bit strobe, a data-available flag, the shifter's serial output and the FIFO fill count.

Software programs one control word through a byte-lane write port. The low lane holds the single-bit controls. The next lane holds the RTS threshold. In hardware mode RTS asks the remote sender to pause once the receive FIFO holds at least the threshold number of entries. In software mode RTS follows a programmed bit. When CTS gating is enabled, the CTS pin passes through a synchronizer and holds back new frames. It never cuts short a frame that has already started.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, RTS is low, no transmit start is permitted, no receive start is permitted, and TXD follows the transmit shifter's serial output.
- R2: A write with `reg_be[0]` set loads the control bits from `reg_wdata`: bit 0 break, bit 1 transmit disable, bit 2 receive disable, bit 3 software RTS level, bit 4 CTS gating enable, bit 5 hardware RTS enable. A write with `reg_be[1]` set loads the threshold from bits 11:8. The threshold resets to 1, and the disables reset to 1.
- R3: With hardware RTS enabled and a nonzero threshold, `rts` is high in the cycle after the FIFO count is at or above the threshold.
- R4: A threshold of 0 keeps `rts` low in hardware mode, whatever the FIFO count.
- R5: With hardware RTS disabled, `rts` equals the software RTS bit one cycle later. With hardware RTS enabled, the software bit has no effect.
- R6: In hardware mode `rts` returns low in the cycle after the FIFO count falls below the threshold.
- R7: With CTS gating enabled, `cts_in` high (not clear to send, active low) blocks `tx_start_ok`. A change on `cts_in` reaches the gate after two clock edges. With gating disabled, `cts_in` is ignored.
- R8: Once a frame is launched, `tx_frame_active` stays high until `tx_frame_done` arrives, even if CTS is withdrawn.
- R9: Setting transmit disable during a frame does not end the frame. After the frame completes, no new start is permitted until transmit disable is cleared.
- R10: `rx_start_ok` is high exactly when `start_bit_seen` is high and receive disable is clear. Clearing receive disable does not raise `rts`.
- R11: While break is set, `txd` is low whatever the shifter drives, and no frame may start. Clearing break returns TXD to the shifter.
- R12: `tx_start_ok` is high only when the transmitter is idle, transmit disable is clear, CTS permits, break is clear and `tx_data_avail` is high. A launch happens on each clock edge where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_be | input | WORD_W/8 | Byte-lane enables for the write |
| reg_wdata | input | WORD_W | Control word write data |
| rx_fifo_count | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill count |
| cts_in | input | 1 | CTS pin, asynchronous, active low by default |
| tx_data_avail | input | 1 | Transmit data is waiting |
| tx_frame_done | input | 1 | Strobe: current transmit frame finished |
| start_bit_seen | input | 1 | Strobe: receiver detected a start bit |
| tx_serial | input | 1 | Serial output of the transmit shifter |
| rts | output | 1 | RTS pin, high requests a pause |
| txd | output | 1 | TXD pin |
| tx_start_ok | output | 1 | Permission to launch a transmit frame |
| tx_frame_active | output | 1 | A transmit frame is in progress |
| rx_start_ok | output | 1 | Permission to begin a reception |

## Verification
The bench sets the FIFO count exactly at the threshold, one below it and at the full depth. An off-by-one comparison would then show up as RTS rising or falling a count early. It withdraws CTS and sets transmit disable in the middle of a frame, so a gate that aborts frames drops `tx_frame_active` before the done strobe. It measures the CTS path edge by edge, so a missing or extra synchronizer stage shows as permission one cycle early or late. It also writes single byte lanes, so a decoder that clobbers the other lane loses the reset threshold of 1 or the hardware-mode bit.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
   // control lane bit positions
   localparam int CB_BRK    = 0;
   localparam int CB_TXOFF  = 1;
   localparam int CB_RXOFF  = 2;
   localparam int CB_RTSSW  = 3;
   localparam int CB_CTSEN  = 4;
   localparam int CB_RTSHW  = 5;
   // threshold lane
   localparam int LVL_LSB   = 8;
   localparam int LVL_RESET = 1;

   typedef enum logic {TXS_IDLE = 1'b0, TXS_FRAME = 1'b1} tx_state_e;
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs
   import uart_fc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LVL_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [WORD_W/8-1:0]   be,
   input  logic [WORD_W-1:0]     wdata,
   output logic                  brk,
   output logic                  tx_off,
   output logic                  rx_off,
   output logic                  rts_sw,
   output logic                  cts_en,
   output logic                  rts_hw,
   output logic [LVL_W-1:0]      lvl
);
   localparam int LANES    = WORD_W / 8;
   localparam int CTL_LANE = CB_RTSHW / 8;
   localparam int LVL_LANE = LVL_LSB / 8;

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (LVL_LSB + LVL_W > WORD_W || LVL_LANE >= LANES) begin : g_bad_lvl
      $error("threshold field does not fit the control word");
   end
   if (LVL_LSB / 8 != (LVL_LSB + LVL_W - 1) / 8) begin : g_bad_span
      $error("threshold field must sit in one byte lane");
   end

   logic ctl_we, lvl_we;
   assign ctl_we = we & be[CTL_LANE];
   assign lvl_we = we & be[LVL_LANE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk    <= 1'b0;
         tx_off <= 1'b1;
         rx_off <= 1'b1;
         rts_sw <= 1'b0;
         cts_en <= 1'b0;
         rts_hw <= 1'b0;
      end else if (ctl_we) begin
         brk    <= wdata[CB_BRK];
         tx_off <= wdata[CB_TXOFF];
         rx_off <= wdata[CB_RXOFF];
         rts_sw <= wdata[CB_RTSSW];
         cts_en <= wdata[CB_CTSEN];
         rts_hw <= wdata[CB_RTSHW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      lvl <= LVL_W'(LVL_RESET);
      else if (lvl_we) lvl <= wdata[LVL_LSB +: LVL_W];
   end

   logic unused_bits;
   assign unused_bits = ^{wdata, be};
endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen #(
   parameter int CNT_W = 5,
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_lvl,
   input  logic [LVL_W-1:0] lvl,
   input  logic [CNT_W-1:0] fill,
   output logic             rts
);
   localparam int CW = (CNT_W > LVL_W) ? CNT_W : LVL_W;

   logic thr_on, over, rts_nx;
   assign thr_on = (lvl != '0);
   assign over   = CW'(fill) >= CW'(lvl);
   assign rts_nx = hw_en ? (thr_on & over) : sw_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) rts <= 1'b0;
      else        rts <= rts_nx;
   end

   // R3
   thr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en && lvl != '0 && CW'(fill) >= CW'(lvl)) |=> rts);
   // R4
   thr_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en && lvl == '0) |=> !rts);
   // R5
   sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_en |=> (rts == $past(sw_lvl)));
   // R6
   thr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en && CW'(fill) < CW'(lvl)) |=> !rts);
endmodule

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
   parameter int STAGES  = 2,
   parameter bit ACT_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic clear
);
   localparam logic IDLE_LVL = ACT_LOW ? 1'b1 : 1'b0;

   if (STAGES < 2) begin : g_bad_stages
      $error("CTS synchronizer needs at least two stages");
   end

   logic [STAGES-1:0] sr;
   always_ff @(posedge clk) begin
      if (!rst_n) sr <= {STAGES{IDLE_LVL}};
      else        sr <= {sr[STAGES-2:0], pin};
   end

   if (ACT_LOW) begin : g_act_low
      assign clear = ~sr[STAGES-1];
   end else begin : g_act_high
      assign clear = sr[STAGES-1];
   end
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
   import uart_fc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_off,
   input  logic brk,
   input  logic cts_en,
   input  logic cts_clear,
   input  logic data_avail,
   input  logic frame_done,
   input  logic serial_in,
   output logic start_ok,
   output logic frame_active,
   output logic txd
);
   tx_state_e st, st_nx;
   logic cts_pass;

   assign cts_pass     = ~cts_en | cts_clear;
   assign frame_active = (st == TXS_FRAME);
   assign start_ok     = (st == TXS_IDLE) & ~tx_off & cts_pass & ~brk & data_avail;
   assign txd          = brk ? 1'b0 : serial_in;

   always_comb begin
      st_nx = st;
      unique case (st)
         TXS_IDLE:  if (start_ok)   st_nx = TXS_FRAME;
         TXS_FRAME: if (frame_done) st_nx = TXS_IDLE;
         default:                   st_nx = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= TXS_IDLE;
      else        st <= st_nx;
   end

   // R7
   cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_en && !cts_clear) |-> !start_ok);
   // R8
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && !frame_done) |=> frame_active);
   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && tx_off) |=> !start_ok);
   // R11
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> (!txd && !start_ok));
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
   parameter int FIFO_DEPTH     = 16,
   parameter int WORD_W         = 16,
   parameter int LVL_W          = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit CTS_ACTIVE_LOW = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [WORD_W/8-1:0]               reg_be,
   input  logic [WORD_W-1:0]                 reg_wdata,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_fifo_count,
   input  logic                              cts_in,
   input  logic                              tx_data_avail,
   input  logic                              tx_frame_done,
   input  logic                              start_bit_seen,
   input  logic                              tx_serial,
   output logic                              rts,
   output logic                              txd,
   output logic                              tx_start_ok,
   output logic                              tx_frame_active,
   output logic                              rx_start_ok
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < (1 << LVL_W) - 1) begin : g_bad_depth
      $error("FIFO_DEPTH must reach the largest threshold");
   end

   logic c_brk, c_txoff, c_rxoff, c_rtssw, c_ctsen, c_rtshw;
   logic [LVL_W-1:0] c_lvl;
   logic cts_clear;

   fc_cfg_regs #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .be(reg_be), .wdata(reg_wdata),
      .brk(c_brk), .tx_off(c_txoff), .rx_off(c_rxoff), .rts_sw(c_rtssw),
      .cts_en(c_ctsen), .rts_hw(c_rtshw), .lvl(c_lvl)
   );

   fc_rts_gen #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_rts (
      .clk(clk), .rst_n(rst_n), .hw_en(c_rtshw), .sw_lvl(c_rtssw),
      .lvl(c_lvl), .fill(rx_fifo_count), .rts(rts)
   );

   fc_cts_sync #(.STAGES(SYNC_STAGES), .ACT_LOW(CTS_ACTIVE_LOW)) u_cts (
      .clk(clk), .rst_n(rst_n), .pin(cts_in), .clear(cts_clear)
   );

   fc_tx_gate u_tx (
      .clk(clk), .rst_n(rst_n), .tx_off(c_txoff), .brk(c_brk),
      .cts_en(c_ctsen), .cts_clear(cts_clear), .data_avail(tx_data_avail),
      .frame_done(tx_frame_done), .serial_in(tx_serial),
      .start_ok(tx_start_ok), .frame_active(tx_frame_active), .txd(txd)
   );

   assign rx_start_ok = start_bit_seen & ~c_rxoff;

   // R10
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_bit_seen |-> !rx_start_ok);
   // R12
   start_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_ok |-> (tx_data_avail && !tx_frame_active));
endmodule

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [1:0] reg_be = '0;
   logic [15:0] reg_wdata = '0;
   logic [CNT_W-1:0] cnt = '0;
   logic cts_in = 1'b0;
   logic data_av = 1'b0;
   logic done = 1'b0;
   logic sbit = 1'b0;
   logic ser = 1'b1;
   logic rts, txd, start_ok, factive, rx_ok;

   int n_vec = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_flow_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .rx_fifo_count(cnt), .cts_in(cts_in),
      .tx_data_avail(data_av), .tx_frame_done(done), .start_bit_seen(sbit),
      .tx_serial(ser), .rts(rts), .txd(txd), .tx_start_ok(start_ok),
      .tx_frame_active(factive), .rx_start_ok(rx_ok)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [15:0] word(input logic brk, txoff, rxoff, sw, ctsen, hw,
                                        input logic [3:0] lvl);
      return {4'b0, lvl, 2'b0, hw, ctsen, sw, rxoff, txoff, brk};
   endfunction

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      reg_we = 1'b1; reg_be = be; reg_wdata = d;
      tick();
      reg_we = 1'b0; reg_be = '0;
   endtask

   task automatic t_reset();
      data_av = 1'b1; cts_in = 1'b0; sbit = 1'b1; cnt = 5'd16; ser = 1'b1;
      #1;
      check("R1 start_ok", start_ok, 0);
      check("R1 rx_ok", rx_ok, 0);
      check("R1 rts", rts, 0);
      check("R1 txd hi", txd, 1);
      ser = 1'b0; #1;
      check("R1 txd lo", txd, 0);
      ser = 1'b1; data_av = 1'b0; sbit = 1'b0; cnt = '0;
   endtask

   task automatic t_hw_rts();
      cnt = 5'd1;
      wr(2'b01, word(0, 1, 0, 0, 0, 1, 4'd9));   // only control lane
      tick();
      check("R2 reset threshold 1", rts, 1);
      cnt = 5'd0; tick();
      check("R6 below 1", rts, 0);
      cnt = 5'd4;
      wr(2'b10, word(0, 0, 1, 0, 0, 0, 4'd5));   // only threshold lane
      tick();
      check("R2 lane kept hw mode / R3 below", rts, 0);
      cnt = 5'd5; tick();
      check("R3 at threshold", rts, 1);
      cnt = 5'd16; tick();
      check("R3 full", rts, 1);
      cnt = 5'd4; tick();
      check("R6 drop", rts, 0);
   endtask

   task automatic t_lvl0();
      cnt = 5'd16;
      wr(2'b10, word(0, 0, 0, 0, 0, 0, 4'd0));
      tick();
      check("R4 full lvl0", rts, 0);
      cnt = 5'd15; tick();
      check("R4 15 lvl0", rts, 0);
      cnt = 5'd0;
      wr(2'b10, word(0, 0, 0, 0, 0, 0, 4'd5));
   endtask

   task automatic t_sw_rts();
      wr(2'b01, word(0, 1, 0, 1, 0, 0, 4'd0));
      tick();
      check("R5 sw high", rts, 1);
      cnt = 5'd16;
      wr(2'b01, word(0, 1, 0, 0, 0, 0, 4'd0));
      tick();
      check("R5 sw low", rts, 0);
      cnt = 5'd0;
      wr(2'b01, word(0, 1, 0, 1, 0, 1, 4'd0));
      tick();
      check("R5 sw ignored hw", rts, 0);
   endtask

   task automatic t_rx();
      wr(2'b01, word(0, 1, 1, 0, 0, 1, 4'd0));
      sbit = 1'b1; #1;
      check("R10 rx disabled", rx_ok, 0);
      wr(2'b01, word(0, 1, 0, 0, 0, 1, 4'd0));
      #1;
      check("R10 rx enabled", rx_ok, 1);
      tick();
      check("R10 no rts", rts, 0);
      sbit = 1'b0; #1;
      check("R10 no start bit", rx_ok, 0);
   endtask

   task automatic t_tx();
      data_av = 1'b0;
      wr(2'b01, word(0, 0, 0, 0, 0, 0, 4'd0));
      #1;
      check("R12 no data", start_ok, 0);
      data_av = 1'b1; #1;
      check("R12 all true", start_ok, 1);
      tick();
      check("R12 launched", factive, 1);
      check("R12 busy blocks", start_ok, 0);
      wr(2'b01, word(0, 1, 0, 0, 0, 0, 4'd0));
      tick();
      check("R9 frame continues", factive, 1);
      done = 1'b1; tick(); done = 1'b0; #1;
      check("R9 frame ended", factive, 0);
      check("R9 no restart", start_ok, 0);
      wr(2'b01, word(0, 0, 0, 0, 0, 0, 4'd0));
      #1;
      check("R9 re-enabled", start_ok, 1);
      data_av = 1'b0;
   endtask

   task automatic t_cts();
      cts_in = 1'b1;
      wr(2'b01, word(0, 0, 0, 0, 1, 0, 4'd0));
      repeat (3) tick();
      data_av = 1'b1; #1;
      check("R7 blocked", start_ok, 0);
      cts_in = 1'b0;
      tick();
      check("R7 sync edge 1", start_ok, 0);
      tick();
      check("R7 sync edge 2", start_ok, 1);
      tick();
      check("R8 launched", factive, 1);
      data_av = 1'b0; cts_in = 1'b1;
      repeat (3) tick();
      check("R8 not aborted", factive, 1);
      done = 1'b1; tick(); done = 1'b0;
      check("R8 done", factive, 0);
      data_av = 1'b1; #1;
      check("R7 still blocked", start_ok, 0);
      wr(2'b01, word(0, 0, 0, 0, 0, 0, 4'd0));
      #1;
      check("R7 ignored when off", start_ok, 1);
      data_av = 1'b0; cts_in = 1'b0;
   endtask

   task automatic t_brk();
      ser = 1'b1;
      wr(2'b01, word(1, 0, 0, 0, 0, 0, 4'd0));
      #1;
      check("R11 txd low", txd, 0);
      ser = 1'b0; #1; ser = 1'b1; #1;
      check("R11 held low", txd, 0);
      data_av = 1'b1; #1;
      check("R11 start blocked", start_ok, 0);
      data_av = 1'b0;
      wr(2'b01, word(0, 0, 0, 0, 0, 0, 4'd0));
      #1;
      check("R11 released hi", txd, 1);
      ser = 1'b0; #1;
      check("R11 released lo", txd, 0);
      ser = 1'b1;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_hw_rts();
      t_lvl0();
      t_sw_rts();
      t_rx();
      t_tx();
      t_cts();
      t_brk();
      repeat (2) tick();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule